// File: doc/BRIEF.md
# Two-Wire Octal DAC Register Front End

This block is the digital front end of an eight-channel voltage-output converter. It listens on a two-wire serial bus as a write-only target. It answers its own 7-bit address, whose low bits come from a three-level strap pin, and it also answers a shared broadcast address. A write frame carries a command/access byte and then one or more pairs of data bytes. From these the block updates a bank of per-channel input registers, DAC registers and power-down modes. Every channel's DAC register code and power-down mode is driven out in parallel to the analog core.

Updates take effect on the falling clock edge that ends the acknowledge cycle after the low data byte. They do not wait for the STOP condition. A frame that a START or STOP cuts short inside a byte leaves every register as it was. Two strobe inputs work outside the bus. A falling edge on the load strobe copies every input register into its DAC register. A low level on the clear input holds every DAC register at zero-scale.

The serial lines and both strobes are sampled by the system clock through two-flop synchronizers. The pad is open-drain, so the block drives only an output-enable that pulls the data line low. The register outputs are plain levels with no handshake: the analog core reads them continuously, and there is no back-pressure at any port.

Top module: `i2c_octal_dac_ctrl`

## Requirements
- R1: After reset every DAC code is zero, every power-down mode is 00 (powered up) and sda_oe is low.
- R2: The own address is binary 1001 followed by three bits picked by addr_sel: 00 gives 000, 01 gives 010, and 10 or 11 (floating) gives 100. The R/W bit must be 0. A match is acknowledged by driving sda_oe high for the 9th clock. A non-matching address, or a read request, is not acknowledged, and every later byte is then ignored and left unacknowledged until the next START.
- R3: The broadcast address byte 0x8E is acknowledged, and the frame that follows acts on this block's registers exactly as if it had been addressed directly.
- R4: The byte after the address has the command in bits 7:4 and the access field in bits 3:0. Access 0 to 7 selects that single channel, 15 selects all channels, and any other value selects none. Every data byte is acknowledged. After a low data byte, further byte pairs are taken as new high/low pairs under the same command byte.
- R5: A register update takes effect after the SCL falling edge that ends the acknowledge cycle following the low data byte. It is not visible during that cycle's SCL high phase, and it needs no STOP.
- R6: The code is the top CODE_W bits of the 16-bit word formed by the high data byte and the low data byte. The bits below it do not change any code.
- R7: Command 0000 writes the input register of the selected channels. Command 0001 copies each selected input register into its DAC register. Command 0011 writes both the input register and the DAC register of the selected channels. Command 0010 writes the selected input registers and then loads every channel's DAC register from its input register. The other command codes, apart from 0100, change nothing.
- R8: Command 0100 sets the power-down mode from data bits 14:13 (00 on, 01 with a 1k load, 10 with a 100k load, 11 high-Z). The mode goes to every channel n whose mask bit 5+n of the data word is set, and the access field is ignored. The mode never alters a DAC code.
- R9: A falling edge on ldac_n copies every input register into its DAC register.
- R10: While clr_n is low, every DAC register is held at zero. Clear wins over the load strobe and over bus updates, and it leaves the input registers untouched.
- R11: A START or STOP inside a byte aborts the frame, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls the data line low (acknowledge) |
| addr_sel | input | 2 | Strap level: 00 low, 01 high, 10/11 floating |
| ldac_n | input | 1 | Load strobe; falling edge loads all DAC registers |
| clr_n | input | 1 | Clear level; low holds DAC registers at zero |
| dac_code | output | NCH*CODE_W | DAC register codes, channel 0 in the low bits |
| pd_mode | output | 2*NCH | Power-down modes, two bits per channel, channel 0 lowest |

## Verification
A corrupted bit counter or frame state shows up first on sda_oe. An acknowledge lands in the wrong clock, or a foreign address is answered, and the master sees this within one byte. A wrong command decode or channel selection shows up on dac_code or pd_mode a few system clocks after the acknowledge edge that ends the low data byte, well before STOP. A lost or spurious strobe edge shows up at the same point, as does a clear that fails to win priority. The bench compares every output against its own register model after each frame and after each strobe.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_CMD,
    LK_HI,
    LK_LO,
    LK_SKIP
  } link_state_e;

  localparam logic [3:0] OP_WR_IN   = 4'b0000;
  localparam logic [3:0] OP_LOAD    = 4'b0001;
  localparam logic [3:0] OP_WR_ALL  = 4'b0010;
  localparam logic [3:0] OP_WR_UPD  = 4'b0011;
  localparam logic [3:0] OP_PWRDN   = 4'b0100;
  localparam logic [3:0] ACC_ALL    = 4'hF;
  localparam logic [7:0] BCAST_BYTE = 8'h8E;

  function automatic logic [6:0] strap_addr(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'b1001_000;
      2'b01:   return 7'b1001_010;
      default: return 7'b1001_100;
    endcase
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] s0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= '1;
      q  <= '1;
    end else begin
      s0 <= d;
      q  <= s0;
    end
  end
endmodule

// File: rtl/i2c_line_cond.sv
module i2c_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_bit,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [1:0] lines_s;
  logic       scl_p, sda_p;

  pin_sync #(.N(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    (lines_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= lines_s[1];
      sda_p <= lines_s[0];
    end
  end

  assign sda_bit  = lines_s[0];
  assign scl_rise = lines_s[1] & ~scl_p;
  assign scl_fall = ~lines_s[1] & scl_p;
  assign start_c  = lines_s[1] & scl_p & sda_p & ~lines_s[0];
  assign stop_c   = lines_s[1] & scl_p & ~sda_p & lines_s[0];
endmodule

// File: rtl/i2c_wr_link.sv
module i2c_wr_link
  import dac_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  own_addr,
  input  logic        sda_bit,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_c,
  input  logic        stop_c,
  output logic        sda_oe,
  output logic        ack_phase,
  output logic        commit,
  output logic [3:0]  cmd,
  output logic [3:0]  acc,
  output logic [15:0] word
);
  link_state_e st;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg;
  logic [7:0]  cmd_q;
  logic [7:0]  hi_q;
  logic        addr_hit;

  assign addr_hit = (shreg == BCAST_BYTE) ||
                    ((shreg[7:1] == own_addr) && !shreg[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LK_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      cmd_q     <= '0;
      hi_q      <= '0;
      word      <= '0;
      sda_oe    <= 1'b0;
      ack_phase <= 1'b0;
      commit    <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start_c) begin
        st        <= LK_ADDR;
        bit_cnt   <= '0;
        sda_oe    <= 1'b0;
        ack_phase <= 1'b0;
      end else if (stop_c) begin
        st        <= LK_IDLE;
        bit_cnt   <= '0;
        sda_oe    <= 1'b0;
        ack_phase <= 1'b0;
      end else if (st != LK_IDLE && st != LK_SKIP) begin
        if (scl_rise && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_bit};
          bit_cnt <= bit_cnt + 4'd1;
        end
        if (scl_fall && bit_cnt == 4'd8) begin
          if (!ack_phase) begin
            // byte complete: decide on acknowledge
            case (st)
              LK_ADDR: begin
                if (addr_hit) begin
                  sda_oe    <= 1'b1;
                  ack_phase <= 1'b1;
                end else begin
                  st <= LK_SKIP;
                end
              end
              LK_CMD: begin
                cmd_q     <= shreg;
                sda_oe    <= 1'b1;
                ack_phase <= 1'b1;
              end
              LK_HI: begin
                hi_q      <= shreg;
                sda_oe    <= 1'b1;
                ack_phase <= 1'b1;
              end
              default: begin
                word      <= {hi_q, shreg};
                sda_oe    <= 1'b1;
                ack_phase <= 1'b1;
              end
            endcase
          end else begin
            // acknowledge clock ends here
            sda_oe    <= 1'b0;
            ack_phase <= 1'b0;
            bit_cnt   <= '0;
            case (st)
              LK_ADDR: st <= LK_CMD;
              LK_CMD:  st <= LK_HI;
              LK_HI:   st <= LK_LO;
              default: begin
                st     <= LK_HI;
                commit <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  assign cmd = cmd_q[7:4];
  assign acc = cmd_q[3:0];
endmodule

// File: rtl/dac_bank.sv
module dac_bank
  import dac_ctrl_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CODE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [3:0]            cmd,
  input  logic [3:0]            acc,
  input  logic [15:0]           word,
  input  logic                  ldac_pulse,
  input  logic                  clr_act,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [2*NCH-1:0]      pd_mode
);
  localparam int CODE_LSB = 16 - CODE_W;
  localparam int MASK_LSB = 5;

  logic [CODE_W-1:0] new_code;
  logic              op_wr_in, op_load, op_wr_all, op_wr_upd, op_pd;

  assign new_code  = word[15:CODE_LSB];
  assign op_wr_in  = commit && (cmd == OP_WR_IN);
  assign op_load   = commit && (cmd == OP_LOAD);
  assign op_wr_all = commit && (cmd == OP_WR_ALL);
  assign op_wr_upd = commit && (cmd == OP_WR_UPD);
  assign op_pd     = commit && (cmd == OP_PWRDN);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] in_q;
    logic [CODE_W-1:0] out_q;
    logic [1:0]        pd_q;

    assign hit = (acc == 4'(i)) || (acc == ACC_ALL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q <= '0;
      end else if (hit && (op_wr_in || op_wr_upd || op_wr_all)) begin
        in_q <= new_code;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_q <= '0;
      end else if (clr_act) begin
        out_q <= '0;
      end else if (ldac_pulse) begin
        out_q <= in_q;
      end else if (op_wr_all) begin
        out_q <= hit ? new_code : in_q;
      end else if (hit && op_wr_upd) begin
        out_q <= new_code;
      end else if (hit && op_load) begin
        out_q <= in_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pd_q <= 2'b00;
      end else if (op_pd && word[MASK_LSB+i]) begin
        pd_q <= word[14:13];
      end
    end

    assign dac_code[i*CODE_W +: CODE_W] = out_q;
    assign pd_mode[2*i +: 2]            = pd_q;
  end
endmodule

// File: rtl/i2c_octal_dac_ctrl.sv
module i2c_octal_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CODE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [1:0]            addr_sel,
  input  logic                  ldac_n,
  input  logic                  clr_n,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [2*NCH-1:0]      pd_mode
);
  logic        sda_bit, scl_rise, scl_fall, start_c, stop_c;
  logic        ack_phase, commit_stb;
  logic [3:0]  cmd, acc;
  logic [15:0] word;
  logic [1:0]  strobe_s;
  logic        ldac_prev, ldac_pulse, clr_act;

  i2c_line_cond u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_bit (sda_bit),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c)
  );

  i2c_wr_link u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_addr (strap_addr(addr_sel)),
    .sda_bit  (sda_bit),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .sda_oe   (sda_oe),
    .ack_phase(ack_phase),
    .commit   (commit_stb),
    .cmd      (cmd),
    .acc      (acc),
    .word     (word)
  );

  pin_sync #(.N(2)) u_strobe_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ldac_n, clr_n}),
    .q    (strobe_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldac_prev <= 1'b1;
    else        ldac_prev <= strobe_s[1];
  end

  assign ldac_pulse = ldac_prev & ~strobe_s[1];
  assign clr_act    = ~strobe_s[0];

  dac_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit_stb),
    .cmd       (cmd),
    .acc       (acc),
    .word      (word),
    .ldac_pulse(ldac_pulse),
    .clr_act   (clr_act),
    .dac_code  (dac_code),
    .pd_mode   (pd_mode)
  );
endmodule

// File: rtl/dac_ctrl_checker.sv
module dac_ctrl_checker #(
  parameter int NCH    = 8,
  parameter int CODE_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sda_oe,
  input logic                  ack_phase,
  input logic                  commit_stb,
  input logic                  ldac_pulse,
  input logic                  clr_act,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic [2*NCH-1:0]      pd_mode
);
  assert_oe_in_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> ack_phase);

  assert_commit_at_ack_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> ($past(ack_phase) && !ack_phase));

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (dac_code == '0));

  assert_pd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_stb |=> $stable(pd_mode));

  assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_stb && !ldac_pulse && !clr_act) |=> $stable(dac_code));
endmodule

bind i2c_octal_dac_ctrl dac_ctrl_checker #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_oe    (sda_oe),
  .ack_phase (ack_phase),
  .commit_stb(commit_stb),
  .ldac_pulse(ldac_pulse),
  .clr_act   (clr_act),
  .dac_code  (dac_code),
  .pd_mode   (pd_mode)
);

// File: tb/sim_i2c_octal_dac_ctrl.sv
module sim_i2c_octal_dac_ctrl;
  localparam int NCH = 8;
  localparam int CW  = 12;
  localparam int T   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic ldac_n = 1'b1;
  logic clr_n = 1'b1;
  logic sda_oe;
  logic [NCH*CW-1:0] dac_code;
  logic [2*NCH-1:0]  pd_mode;
  wire sda_bus = sda_m & ~sda_oe;

  int n_tests = 0;
  int n_fail  = 0;
  logic [CW-1:0] m_in  [NCH];
  logic [CW-1:0] m_dac [NCH];
  logic [1:0]    m_pd  [NCH];

  always #2 clk = ~clk;

  i2c_octal_dac_ctrl #(.NCH(NCH), .CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .ldac_n(ldac_n), .clr_n(clr_n),
    .dac_code(dac_code), .pd_mode(pd_mode)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NCH*CW-1:0] exp_code();
    logic [NCH*CW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*CW +: CW] = m_dac[i];
    return v;
  endfunction

  function automatic logic [2*NCH-1:0] exp_pd();
    logic [2*NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[2*i +: 2] = m_pd[i];
    return v;
  endfunction

  function automatic logic [7:0] own_byte(logic [1:0] sel);
    logic [2:0] lo;
    lo = (sel == 2'b00) ? 3'b000 : (sel == 2'b01) ? 3'b010 : 3'b100;
    return {4'b1001, lo, 1'b0};
  endfunction

  task automatic model_commit(logic [7:0] cb, logic [15:0] wd);
    logic [3:0] c, a;
    logic [CW-1:0] code;
    c = cb[7:4];
    a = cb[3:0];
    code = wd[15:16-CW];
    for (int i = 0; i < NCH; i++) begin
      logic sel;
      sel = (a == 4'(i)) || (a == 4'hF);
      case (c)
        4'h0: if (sel) m_in[i] = code;
        4'h1: if (sel) m_dac[i] = m_in[i];
        4'h2: begin if (sel) m_in[i] = code; m_dac[i] = m_in[i]; end
        4'h3: if (sel) begin m_in[i] = code; m_dac[i] = code; end
        4'h4: if (wd[5+i]) m_pd[i] = wd[14:13];
        default: ;
      endcase
    end
  endtask

  task automatic check_all(string req);
    tick(6);
    check(req, 128'(dac_code), 128'(exp_code()));
    check(req, 128'(pd_mode), 128'(exp_pd()));
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(2*T);
    sda_m = 1'b0; tick(2*T);
    scl_m = 1'b0; tick(T);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(T);
    scl_m = 1'b1; tick(2*T);
    sda_m = 1'b1; tick(2*T);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(T);
    scl_m = 1'b1; tick(2*T);
    scl_m = 1'b0; tick(T);
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    acked = ~sda_bus;
    tick(T);
    scl_m = 1'b0; tick(T);
  endtask

  task automatic frame(logic [7:0] ab, logic [7:0] cb, logic [15:0] wd,
                       output logic [3:0] acks);
    logic a0, a1, a2, a3;
    i2c_start();
    send_byte(ab, a0);
    send_byte(cb, a1);
    send_byte(wd[15:8], a2);
    send_byte(wd[7:0], a3);
    i2c_stop();
    acks = {a0, a1, a2, a3};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] acks;
    logic ak;
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_dac[i] = '0; m_pd[i] = 2'b00; end
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    check("R1 code", 128'(dac_code), 128'(0));
    check("R1 pd", 128'(pd_mode), 128'(0));
    check("R1 oe", 128'(sda_oe), 128'(0));

    // R2 own address for each strap level, write-through to DAC
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s);
      tick(4);
      frame(own_byte(2'(s)), 8'h30 | 8'(s), 16'h1230 + 16'(s << 4), acks);
      check("R2 ack own", 128'(acks), 128'(4'hF));
      model_commit(8'h30 | 8'(s), 16'h1230 + 16'(s << 4));
      check_all("R2 write");
    end

    // R2 mismatched address and read request ignored
    addr_sel = 2'b01;
    frame(own_byte(2'b00), 8'h3F, 16'hABC0, acks);
    check("R2 nack foreign", 128'(acks), 128'(0));
    check_all("R2 foreign no effect");
    frame(own_byte(2'b01) | 8'h01, 8'h3F, 16'hABC0, acks);
    check("R2 nack read", 128'(acks), 128'(0));
    check_all("R2 read no effect");

    // R3 broadcast
    frame(8'h8E, 8'h3F, 16'h7770, acks);
    check("R3 ack bcast", 128'(acks), 128'(4'hF));
    model_commit(8'h3F, 16'h7770);
    check_all("R3 bcast write");

    // R6 low bits ignored
    frame(own_byte(2'b01), 8'h32, 16'h5A5F, acks);
    model_commit(8'h32, 16'h5A5F);
    check_all("R6 low bits");
    check("R6 ch2 code", 128'(dac_code[2*CW +: CW]), 128'(12'h5A5));

    // R4 unused access value selects nothing
    frame(own_byte(2'b01), 8'h3A, 16'hFFF0, acks);
    check_all("R4 access 10");

    // R4 continued pairs with one command byte
    i2c_start();
    send_byte(own_byte(2'b01), ak);
    send_byte(8'h35, ak);
    send_byte(8'h11, ak); send_byte(8'h10, ak);
    send_byte(8'h22, ak); send_byte(8'h20, ak);
    i2c_stop();
    model_commit(8'h35, 16'h1110);
    model_commit(8'h35, 16'h2220);
    check_all("R4 repeated pair");
    check("R4 ch5 last", 128'(dac_code[5*CW +: CW]), 128'(12'h222));

    // R5 commit at acknowledge end, before STOP
    i2c_start();
    send_byte(own_byte(2'b01), ak);
    send_byte(8'h37, ak);
    send_byte(8'hC3, ak);
    for (int k = 7; k >= 0; k--) send_bit(ak ? 1'b0 : 1'b0);
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    check("R5 not during ack high", 128'(dac_code[7*CW +: CW]), 128'(m_dac[7]));
    tick(T);
    scl_m = 1'b0; tick(6);
    check("R5 after ack fall", 128'(dac_code[7*CW +: CW]), 128'(12'hC30));
    i2c_stop();
    model_commit(8'h37, 16'hC300);
    check_all("R5 after stop");

    // R11 START inside low byte aborts
    i2c_start();
    send_byte(own_byte(2'b01), ak);
    send_byte(8'h3F, ak);
    send_byte(8'h99, ak);
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    i2c_start();
    i2c_stop();
    check_all("R11 start abort");
    // R11 STOP inside command byte aborts
    i2c_start();
    send_byte(own_byte(2'b01), ak);
    for (int k = 0; k < 3; k++) send_bit(1'b0);
    i2c_stop();
    check_all("R11 stop abort");

    // R7 input write then sync load
    frame(own_byte(2'b01), 8'h04, 16'h8880, acks);
    model_commit(8'h04, 16'h8880);
    check_all("R7 input only");
    frame(own_byte(2'b01), 8'h14, 16'h0000, acks);
    model_commit(8'h14, 16'h0000);
    check_all("R7 sync load");
    check("R7 ch4", 128'(dac_code[4*CW +: CW]), 128'(12'h888));

    // R9 load strobe
    frame(own_byte(2'b01), 8'h0F, 16'h4560, acks);
    model_commit(8'h0F, 16'h4560);
    check_all("R9 before strobe");
    ldac_n = 1'b0; tick(4); ldac_n = 1'b1;
    for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
    check_all("R9 strobe");

    // R8 power-down mask and modes
    frame(own_byte(2'b01), 8'h40, 16'h6000 | 16'(8'b1010_0101 << 5), acks);
    model_commit(8'h40, 16'h6000 | 16'(8'b1010_0101 << 5));
    check_all("R8 pd 11");
    frame(own_byte(2'b01), 8'h43, 16'h2000 | 16'(8'b0000_0011 << 5), acks);
    model_commit(8'h43, 16'h2000 | 16'(8'b0000_0011 << 5));
    check_all("R8 pd 01");
    check("R8 ch0 mode", 128'(pd_mode[1:0]), 128'(2'b01));

    // R10 clear wins over load strobe, inputs kept
    clr_n = 1'b0; tick(3);
    ldac_n = 1'b0; tick(4); ldac_n = 1'b1;
    for (int i = 0; i < NCH; i++) m_dac[i] = '0;
    check_all("R10 clear held");
    clr_n = 1'b1; tick(4);
    frame(own_byte(2'b01), 8'h1F, 16'h0000, acks);
    model_commit(8'h1F, 16'h0000);
    check_all("R10 inputs kept");

    // random mix of commands, channels and data
    for (int n = 0; n < 60; n++) begin
      logic [3:0] c, a;
      logic [15:0] wd;
      int rc, ra;
      rc = int'($urandom % 6);
      ra = int'($urandom % 10);
      c  = (rc == 5) ? 4'h9 : 4'(rc);
      a  = (ra == 8) ? 4'hF : (ra == 9) ? 4'hC : 4'(ra);
      wd = 16'($urandom);
      frame(own_byte(2'b01), {c, a}, wd, acks);
      check("R4 random acks", 128'(acks), 128'(4'hF));
      model_commit({c, a}, wd);
      check_all("R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule